// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block turns a single-cycle internal write request into a full write cycle on an asynchronous static-RAM port that has byte lanes. The port signals are a chip select, a semaphore select, a read/write strobe, an output enable, upper and lower byte enables, an address and a data bus. The data bus is brought out as a data value plus a drive enable, which the enclosing pad logic turns into a tristate. Every interval is a parameter counted in clock cycles: address setup, minimum write pulse, output turn-off, data setup, address hold and data hold.

Each request names the target, either RAM or semaphore. It also names the byte lanes, the strobe style and whether output enable stays low during the write. The strobe style is either read/write-controlled or select-controlled. In the read/write-controlled style, output enable can be held low. In that case the memory may still drive the bus when the strobe falls. The sequencer therefore keeps its own drivers off for the turn-off interval and lengthens the pulse so that the full data setup still fits inside it.

Requests use a valid/ready handshake. Each completed cycle ends with a one-cycle done pulse.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held, req_ready_o is 1, done_o is 0, mem_data_oe_o is 0, and all of mem_ce_no, mem_sem_no, mem_rw_no, mem_oe_no, mem_ub_no and mem_lb_no are 1.
- R2: A request is taken only on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the next cycle through the done cycle and returns to 1 in the cycle after it. req_valid_i is ignored while ready is 0.
- R3: mem_addr_o is loaded only on acceptance and holds the request address for the whole cycle. mem_rw_no is 1 in any cycle in which the address changes, and also in the cycle before it.
- R4: In read/write-controlled mode (req_ce_mode_i=0), the select and the chosen byte enables go low in the first cycle after acceptance. mem_rw_no goes low T_AS cycles later. All strobes rise together at the end of the pulse.
- R5: In read/write-controlled mode, mem_rw_no stays low for max(T_PW, T_OFF+T_DS) cycles when output enable is held low, and for T_PW cycles otherwise.
- R6: In select-controlled mode (req_ce_mode_i=1), the byte enables go low first. After T_AS cycles, mem_rw_no and the select fall in the same cycle, stay low for T_PW cycles and rise together.
- R7: When req_sem_i=0, mem_ce_no is the select and mem_sem_no stays 1. When req_sem_i=1, the roles swap. req_be_i[1]=1 drives mem_ub_no low and writes data bits [DW-1:DW/2]. req_be_i[0]=1 drives mem_lb_no low and writes the lower half.
- R8: mem_data_oe_o is 0 for the first T_OFF pulse cycles in read/write-controlled mode with output enable low. Otherwise it is 1 from the first pulse cycle. It stays 1 for T_DH cycles after the strobes rise. While it is 1, mem_data_o equals the request data.
- R9: After the strobes rise, the address is held with all strobes high for max(T_AH, T_DH) cycles. done_o is then 1 for exactly one cycle.
- R10: A request with req_be_i=0 asserts no strobe. done_o is 1 in the first cycle after acceptance.
- R11: mem_oe_no is 0 from the first cycle after acceptance through the done cycle if req_oe_low_i was 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_addr_i | input | AW | Write address |
| req_data_i | input | DW | Write data |
| req_be_i | input | 2 | Lane select: bit 1 upper, bit 0 lower |
| req_sem_i | input | 1 | 1 targets the semaphore select, 0 the chip select |
| req_ce_mode_i | input | 1 | 1 select-controlled, 0 read/write-controlled |
| req_oe_low_i | input | 1 | Hold output enable low during the cycle |
| done_o | output | 1 | One-cycle end-of-cycle pulse |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_sem_no | output | 1 | Semaphore select, active low |
| mem_rw_no | output | 1 | Read/write strobe, low writes |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte enable, active low |
| mem_lb_no | output | 1 | Lower byte enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_data_o | output | DW | Write data towards the pads |
| mem_data_oe_o | output | 1 | Data pad drive enable |

## Verification
The bench builds the block with T_AS=2, T_PW=3, T_OFF=2, T_DS=2, T_AH=1 and T_DH=2. Because T_OFF+T_DS exceeds T_PW, the stretched pulse is one cycle longer than the plain one. Because T_DH exceeds T_AH, the data-hold count sets the hold length. The bench sweeps all 32 combinations of strobe style, output-enable choice, target select and lane mask, each with its own address and data. It compares every pin in every cycle of every transfer against a cycle-indexed model. Requests are left valid with decoy values while the block is busy, so any premature acceptance shows up as a wrong address or a missing ready.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } wr_state_e;
endpackage

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_PW  = 2,
  parameter int T_OFF = 1,
  parameter int T_DS  = 1,
  parameter int T_AH  = 1,
  parameter int T_DH  = 1,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [1:0]    req_be_i,
  input  logic          req_sem_i,
  input  logic          req_ce_mode_i,
  input  logic          req_oe_low_i,
  output wr_state_e     state_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [1:0]    be_o,
  output logic          sem_o,
  output logic          ce_mode_o,
  output logic          oe_low_o,
  output logic          ready_o,
  output logic          done_o
);
  localparam int PW_WAIT  = (T_OFF + T_DS > T_PW) ? T_OFF + T_DS : T_PW;
  localparam int HOLD_LEN = (T_AH > T_DH) ? T_AH : T_DH;
  localparam logic [CW-1:0] AS_LAST   = CW'(T_AS - 1);
  localparam logic [CW-1:0] PW_LAST   = CW'(T_PW - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(PW_WAIT - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_LEN - 1);

  wr_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pulse_last;

  // stretched pulse only when the memory may still drive the bus
  assign pulse_last = (!ce_mode_o && oe_low_o) ? WAIT_LAST : PW_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_o    <= '0;
      data_o    <= '0;
      be_o      <= '0;
      sem_o     <= 1'b0;
      ce_mode_o <= 1'b0;
      oe_low_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_o    <= req_addr_i;
          data_o    <= req_data_i;
          be_o      <= req_be_i;
          sem_o     <= req_sem_i;
          ce_mode_o <= req_ce_mode_i;
          oe_low_o  <= req_oe_low_i;
          cnt_q     <= '0;
          state_q   <= (req_be_i == 2'b00) ? ST_DONE : ST_SETUP;
        end
        ST_SETUP: if (cnt_q == AS_LAST) begin
          cnt_q <= '0; state_q <= ST_PULSE;
        end else cnt_q <= cnt_q + 1'b1;
        ST_PULSE: if (cnt_q == pulse_last) begin
          cnt_q <= '0; state_q <= ST_HOLD;
        end else cnt_q <= cnt_q + 1'b1;
        ST_HOLD: if (cnt_q == HOLD_LAST) begin
          cnt_q <= '0; state_q <= ST_DONE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = (state_q == ST_DONE);

  assert_ready_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_o));
  assert_empty_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i && req_be_i == 2'b00) |=> done_o);
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int T_OFF = 1,
  parameter int T_DH  = 1,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_state_e     state_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    be_i,
  input  logic          sem_i,
  input  logic          ce_mode_i,
  input  logic          oe_low_i,
  output logic          mem_ce_no,
  output logic          mem_sem_no,
  output logic          mem_rw_no,
  output logic          mem_oe_no,
  output logic          mem_ub_no,
  output logic          mem_lb_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_data_oe_o
);
  localparam logic [CW-1:0] OFF_CNT = CW'(T_OFF);
  localparam logic [CW-1:0] DH_CNT  = CW'(T_DH);

  logic busy, setup, pulse, hold, sel_low, lanes_on, wait_off;

  always_comb begin
    busy     = (state_i != ST_IDLE);
    setup    = (state_i == ST_SETUP);
    pulse    = (state_i == ST_PULSE);
    hold     = (state_i == ST_HOLD);
    // select-controlled: select falls with rw, never before
    sel_low  = pulse || (setup && !ce_mode_i);
    lanes_on = setup || pulse;
    wait_off = !ce_mode_i && oe_low_i;
    mem_ce_no     = !(sel_low && !sem_i);
    mem_sem_no    = !(sel_low && sem_i);
    mem_rw_no     = !pulse;
    mem_ub_no     = !(lanes_on && be_i[1]);
    mem_lb_no     = !(lanes_on && be_i[0]);
    mem_oe_no     = !(busy && oe_low_i);
    mem_data_oe_o = (pulse && (!wait_off || cnt_i >= OFF_CNT)) ||
                    (hold && cnt_i < DH_CNT);
    mem_addr_o    = addr_i;
    mem_data_o    = data_i;
  end

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_rw_no && $past(mem_rw_no)));
  assert_overlap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rw_no |-> ((!mem_ce_no || !mem_sem_no) && (!mem_ub_no || !mem_lb_no)));
  assert_rw_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_mode_i && ($fell(mem_ce_no) || $fell(mem_sem_no))) |-> !mem_rw_no);
  assert_one_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!mem_ce_no, !mem_sem_no}));
  assert_drive_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_rw_no) && !mem_oe_no && !ce_mode_i) |-> !mem_data_oe_o);
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int T_AS  = 1,
  parameter int T_PW  = 2,
  parameter int T_OFF = 1,
  parameter int T_DS  = 1,
  parameter int T_AH  = 1,
  parameter int T_DH  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  input  logic [1:0]    req_be_i,
  input  logic          req_sem_i,
  input  logic          req_ce_mode_i,
  input  logic          req_oe_low_i,
  output logic          done_o,
  output logic          mem_ce_no,
  output logic          mem_sem_no,
  output logic          mem_rw_no,
  output logic          mem_oe_no,
  output logic          mem_ub_no,
  output logic          mem_lb_no,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_data_oe_o
);
  localparam int M1     = (T_AS > T_PW) ? T_AS : T_PW;
  localparam int M2     = (T_OFF + T_DS > M1) ? T_OFF + T_DS : M1;
  localparam int M3     = (T_AH > M2) ? T_AH : M2;
  localparam int MAXLEN = (T_DH > M3) ? T_DH : M3;
  localparam int CW     = $clog2(MAXLEN + 1);

  wr_state_e     state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [1:0]    be_q;
  logic          sem_q, ce_mode_q, oe_low_q;

  sram_wr_fsm #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_PW(T_PW), .T_OFF(T_OFF),
    .T_DS(T_DS), .T_AH(T_AH), .T_DH(T_DH), .CW(CW)
  ) fsm_i (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_data_i, .req_be_i,
    .req_sem_i, .req_ce_mode_i, .req_oe_low_i,
    .state_o(state), .cnt_o(cnt), .addr_o(addr_q), .data_o(data_q),
    .be_o(be_q), .sem_o(sem_q), .ce_mode_o(ce_mode_q), .oe_low_o(oe_low_q),
    .ready_o(req_ready_o), .done_o(done_o)
  );

  sram_wr_pins #(
    .AW(AW), .DW(DW), .T_OFF(T_OFF), .T_DH(T_DH), .CW(CW)
  ) pins_i (
    .clk_i, .rst_ni, .state_i(state), .cnt_i(cnt), .addr_i(addr_q),
    .data_i(data_q), .be_i(be_q), .sem_i(sem_q), .ce_mode_i(ce_mode_q),
    .oe_low_i(oe_low_q),
    .mem_ce_no, .mem_sem_no, .mem_rw_no, .mem_oe_no, .mem_ub_no, .mem_lb_no,
    .mem_addr_o, .mem_data_o, .mem_data_oe_o
  );
endmodule

// File: tb/sram_wr_seq_tb.sv
`timescale 1ns/1ps
module sram_wr_seq_tb_top;
  localparam int AW = 8, DW = 16;
  localparam int T_AS = 2, T_PW = 3, T_OFF = 2, T_DS = 2, T_AH = 1, T_DH = 2;
  localparam int PW_WAIT = (T_OFF + T_DS > T_PW) ? T_OFF + T_DS : T_PW;
  localparam int HL = (T_AH > T_DH) ? T_AH : T_DH;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_ready, done;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] req_be = '0;
  logic req_sem = 1'b0, req_ce_mode = 1'b0, req_oe_low = 1'b0;
  logic ce_n, sem_n, rw_n, oe_n, ub_n, lb_n, data_oe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mdata;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_PW(T_PW), .T_OFF(T_OFF),
                .T_DS(T_DS), .T_AH(T_AH), .T_DH(T_DH)) dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_be_i(req_be),
    .req_sem_i(req_sem), .req_ce_mode_i(req_ce_mode), .req_oe_low_i(req_oe_low),
    .done_o(done), .mem_ce_no(ce_n), .mem_sem_no(sem_n), .mem_rw_no(rw_n),
    .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n), .mem_addr_o(maddr),
    .mem_data_o(mdata), .mem_data_oe_o(data_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset handshake", {30'd0, req_ready, done}, 32'b10);
    chk("R1 reset strobes", {25'd0, ce_n, sem_n, rw_n, oe_n, ub_n, lb_n, data_oe}, 32'b1111110);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 32; k++) begin
      automatic logic mode = k[4], oe = k[3], sem = k[2];
      automatic logic [1:0] be = k[1:0];
      automatic logic [AW-1:0] a = AW'(k * 37 + 5);
      automatic logic [DW-1:0] d = DW'(k * 4099 + 16'h1234);
      automatic int lp = (!mode && oe) ? PW_WAIT : T_PW;
      automatic int total = (be == 2'b00) ? 1 : T_AS + lp + HL + 1;
      chk("R2 ready idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
      req_sem = sem; req_ce_mode = mode; req_oe_low = oe;
      @(negedge clk);
      // decoy request held valid while busy
      req_addr = ~a; req_data = ~d; req_be = ~be;
      for (int i = 0; i <= total; i++) begin
        automatic int ph, j;
        automatic logic sel_low, lanes, e_rw, e_doe, busy;
        automatic string stag = mode ? "R6" : (oe ? "R5" : "R4");
        if (i == total) ph = 0;
        else if (be == 2'b00 || i == total - 1) ph = 4;
        else if (i < T_AS) begin ph = 1; j = i; end
        else if (i < T_AS + lp) begin ph = 2; j = i - T_AS; end
        else begin ph = 3; j = i - T_AS - lp; end
        busy    = (ph != 0);
        sel_low = (ph == 2) || (ph == 1 && !mode);
        lanes   = (ph == 1) || (ph == 2);
        e_rw    = !(ph == 2);
        e_doe   = (ph == 2 && (mode || !oe || j >= T_OFF)) || (ph == 3 && j < T_DH);
        chk(be == 2'b00 ? "R10 handshake" : "R9 handshake",
            {30'd0, req_ready, done}, {30'd0, ph == 0, ph == 4});
        chk({stag, " rw/select timing"}, {30'd0, rw_n, ce_n & sem_n}, {30'd0, e_rw, !sel_low});
        chk("R7 select/lanes", {28'd0, ce_n, sem_n, ub_n, lb_n},
            {28'd0, !(sel_low && !sem), !(sel_low && sem), !(lanes && be[1]), !(lanes && be[0])});
        chk("R11 output enable", {31'd0, oe_n}, {31'd0, !(busy && oe)});
        chk("R8 data drive", {31'd0, data_oe}, {31'd0, e_doe});
        if (e_doe) chk("R8 data value", {16'd0, mdata}, {16'd0, d});
        if (busy) chk("R3 address held", {24'd0, maddr}, {24'd0, a});
        if (ph == 4) req_valid = 1'b0;
        if (i < total) @(negedge clk);
      end
    end
    chk("R2 no stray accept", {31'd0, req_ready}, 32'd1);
    summary();
  end
endmodule